// File: doc/BRIEF.md
# Cascaded Two-Stage Interrupt Controller Dispatcher

The block pairs two eight-line interrupt controllers, a primary and a secondary, so that one CPU interrupt pin serves sixteen request lines. Lines 0 to 7 belong to the primary. Lines 8 to 15 belong to the secondary, which sees them as its local lines 0 to 7. The secondary is always chained behind primary line 2.

A four-entry register window lets software reach the two controllers. Each access goes to exactly one of them. Software uses this window to run the initialization byte sequence, set masks, send end-of-interrupt commands and read back the in-service bits.

The block forwards a request from the secondary only when the cascade setup is consistent. When it accepts such a request, it updates the in-service state in both controllers. It then raises one interrupt output with one vector, and holds both until the CPU acknowledges.

Top module: `cascaded_pic_pair`

## Requirements
- R1: Address 2'b00 selects the primary command register, 2'b01 the primary data register, 2'b10 the secondary command register and 2'b11 the secondary data register. A data write outside initialization sets only the selected controller's mask, and a data read returns that mask.
- R2: A command write with bit 4 set starts initialization. In that byte, bit 1 set means single mode and bit 0 set means a fourth byte follows. The next data write sets the vector base, with its low three bits forced to zero. In cascade mode the following byte is the cascade byte. If a fourth byte was requested, it comes last, and its bit 1 selects automatic end-of-interrupt.
- R3: An accepted request on primary line n raises int_out with int_vec = primary base + n. Both stay unchanged until int_ack.
- R4: A request on a line whose mask bit is set is not accepted.
- R5: A request on line n of a controller is not accepted while that controller has any in-service bit at index n or below.
- R6: Secondary requests are ignored unless bit 2 of the primary's cascade byte is set and the secondary's cascade byte equals exactly 2.
- R7: A secondary request is not accepted while any primary in-service bit is set.
- R8: Accepting secondary local line k gives int_vec = secondary base + k. It sets primary in-service bit 2 and secondary in-service bit k. Primary bit 2 stays set after an end-of-interrupt to the secondary, until the primary receives its own end-of-interrupt.
- R9: When a primary request and a secondary request are eligible in the same cycle, the primary request is taken and the secondary request is dropped.
- R10: A command write with bits 4 and 3 clear and bit 5 set is an end-of-interrupt. If bit 6 is also set, it clears only the in-service bit numbered by bits 2:0. If bit 6 is clear, it clears all in-service bits. Writing 8'h0B to a command register makes the next read of that command register return its in-service bits. Other command reads return 0.
- R11: A controller in automatic end-of-interrupt mode sets no in-service bit when its request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq | input | 16 | Request lines 0 to 15 |
| addr | input | 2 | Register window select |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (consumes an in-service read) |
| rd_data | output | 8 | Register read data, combinational |
| int_out | output | 1 | Interrupt to the CPU |
| int_vec | output | 8 | Vector of the pending interrupt |
| int_ack | input | 1 | CPU acknowledge, clears int_out |

## Verification
The bench first sets up the secondary with a cascade byte of 3 and sends it a request. A design that skipped the cascade check would produce a spurious vector here. Next it sends an end-of-interrupt to the secondary alone and probes whether primary line 2 is still busy. It does this both by reading the in-service bits and by firing a secondary request that must stay blocked. A design that cleared both controllers together, or that never marked line 2, would let that request through. The bench also fires a primary line and a secondary line together, where a wrong arbiter would emit the secondary's vector. Finally it checks that a lower-priority line is held off by an in-service higher line while a higher line still gets through, which an inverted priority comparison would reverse.

// File: rtl/cascaded_pic_pair.sv
module cascaded_pic_pair (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq,
  input  logic [1:0]  addr,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  output logic        int_out,
  output logic [7:0]  int_vec,
  input  logic        int_ack
);

  logic [7:0] mask [2];
  logic [7:0] isr  [2];
  logic [7:0] isr_clr [2];
  logic [7:0] isr_set [2];
  logic [7:0] casc [2];
  logic [4:0] base [2];
  logic [1:0] cfg  [2];
  logic       init [2];
  logic       need_base [2];
  logic       casc_set [2];
  logic       aeoi [2];
  logic       show_isr [2];

  logic       m_hit, s_hit, take_m, take_s, casc_ok;
  logic [2:0] m_idx, s_idx;

  assign casc_ok = casc[0][2] && (casc[1] == 8'd2);

  always_comb begin
    m_hit = 1'b0; m_idx = 3'd0;
    s_hit = 1'b0; s_idx = 3'd0;
    for (int n = 7; n >= 0; n--) begin
      if (irq[n] && !mask[0][n] && ((isr[0] & 8'((16'd2 << n) - 16'd1)) == 8'd0)) begin
        m_hit = 1'b1; m_idx = 3'(n);
      end
      if (casc_ok && isr[0] == 8'd0 && irq[8+n] && !mask[1][n] &&
          ((isr[1] & 8'((16'd2 << n) - 16'd1)) == 8'd0)) begin
        s_hit = 1'b1; s_idx = 3'(n);
      end
    end
  end

  assign take_m = !int_out && m_hit;
  assign take_s = !int_out && !m_hit && s_hit;

  assign isr_set[0] = aeoi[0] ? 8'd0 : take_m ? (8'd1 << m_idx) : take_s ? 8'h04 : 8'd0;
  assign isr_set[1] = (take_s && !aeoi[1]) ? (8'd1 << s_idx) : 8'd0;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      isr_clr[c] = isr[c];
      if (wr_en && addr == {1'(c), 1'b0} && !wr_data[4] && !wr_data[3] && wr_data[5])
        isr_clr[c] = wr_data[6] ? (isr[c] & ~(8'd1 << wr_data[2:0])) : 8'd0;
    end
  end

  assign rd_data = addr[0] ? mask[addr[1]] : (show_isr[addr[1]] ? isr[addr[1]] : 8'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        mask[c] <= 8'd0; isr[c] <= 8'd0; casc[c] <= 8'd0; base[c] <= 5'd0;
        cfg[c] <= 2'd0; init[c] <= 1'b0; need_base[c] <= 1'b0;
        casc_set[c] <= 1'b0; aeoi[c] <= 1'b0; show_isr[c] <= 1'b0;
      end
      int_out <= 1'b0;
      int_vec <= 8'd0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        isr[c] <= isr_clr[c] | isr_set[c];
        if (rd_en && addr == {1'(c), 1'b0}) show_isr[c] <= 1'b0;
        if (wr_en && addr == {1'(c), 1'b0}) begin
          if (wr_data[4]) begin
            init[c] <= 1'b1; need_base[c] <= 1'b1; casc_set[c] <= 1'b0;
            cfg[c] <= wr_data[1:0]; aeoi[c] <= 1'b0;
          end else if (wr_data[3] && wr_data == 8'h0B) begin
            show_isr[c] <= 1'b1;
          end
        end
        if (wr_en && addr == {1'(c), 1'b1}) begin
          if (!init[c]) begin
            mask[c] <= wr_data;
          end else if (need_base[c]) begin
            base[c] <= wr_data[7:3];
            need_base[c] <= 1'b0;
            if (cfg[c][1] && !cfg[c][0]) init[c] <= 1'b0;
          end else if (!cfg[c][1] && !casc_set[c]) begin
            casc[c] <= wr_data;
            casc_set[c] <= 1'b1;
            if (!cfg[c][0]) init[c] <= 1'b0;
          end else begin
            aeoi[c] <= wr_data[1];
            init[c] <= 1'b0;
          end
        end
      end
      if (int_ack) begin
        int_out <= 1'b0;
      end else if (take_m || take_s) begin
        int_out <= 1'b1;
        int_vec <= take_m ? {base[0], m_idx} : {base[1], s_idx};
      end
    end
  end

  logic [7:0] isr0_q, isr1_q, new0, new1;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr0_q <= 8'd0; isr1_q <= 8'd0;
    end else begin
      isr0_q <= isr[0]; isr1_q <= isr[1];
    end
  end
  assign new0 = isr[0] & ~isr0_q;
  assign new1 = isr[1] & ~isr1_q;

  // R3
  int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out && !int_ack |=> int_out && $stable(int_vec));
  // R5
  prio_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new0 != 8'd0 |-> $onehot0(new0) && ((isr0_q & 8'((new0 << 1) - 8'd1)) == 8'd0));
  // R7
  sec_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new1 != 8'd0 |-> isr0_q == 8'd0);
  // R8
  line2_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new1 != 8'd0 |-> isr[0][2] || aeoi[0]);

endmodule

// File: tb/test_cascaded_pic_pair.sv
module test_cascaded_pic_pair;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = 16'd0;
  logic [1:0]  addr = 2'd0;
  logic        wr_en = 1'b0, rd_en = 1'b0, int_ack = 1'b0;
  logic [7:0]  wr_data = 8'd0;
  logic [7:0]  rd_data, int_vec;
  logic        int_out;

  int checks = 0, failures = 0;
  logic [7:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cascaded_pic_pair i_cascaded_pic_pair (
    .clk(clk), .rst_n(rst_n), .irq(irq), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .int_out(int_out), .int_vec(int_vec), .int_ack(int_ack));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_isr(input logic [1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    wr(a, 8'h0B);
    rd(a, v);
    chk(v == exp, req, v, exp);
  endtask

  task automatic pulse(input logic [15:0] lines);
    irq = lines;
    @(negedge clk);
    irq = 16'd0;
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_vec(input logic [7:0] v);
    exp_q.push_back(v);
  endtask

  // monitor: pops expected vectors as interrupts appear
  initial begin
    logic [7:0] e;
    forever begin
      @(negedge clk);
      if (rst_n && int_out) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "unexpected interrupt (R4/R5/R6/R7/R9)", int_vec, 0);
        end else begin
          e = exp_q.pop_front();
          chk(int_vec == e, "vector R3/R8", int_vec, e);
          repeat (2) @(negedge clk);
          chk(int_out && int_vec == e, "R3 held until ack", int_vec, e);
        end
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk(int_out == 1'b0, "R3 reset int_out", int_out, 0);
    rd(2'b01, v);
    chk(v == 8'h00, "R1 reset mask", v, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: primary cascade mode with fourth byte, base 0x27 -> 0x20
    wr(2'b00, 8'h11); wr(2'b01, 8'h27); wr(2'b01, 8'h04); wr(2'b01, 8'h01);
    // secondary with wrong cascade byte 3
    wr(2'b10, 8'h11); wr(2'b11, 8'h70); wr(2'b11, 8'h03); wr(2'b11, 8'h01);

    // R1 routing
    wr(2'b01, 8'h5A);
    rd(2'b01, v); chk(v == 8'h5A, "R1 primary mask", v, 8'h5A);
    rd(2'b11, v); chk(v == 8'h00, "R1 secondary mask untouched", v, 0);
    wr(2'b01, 8'h00);

    // R2/R3 vector with masked-off base bits
    expect_vec(8'h23); pulse(16'h0008);
    rd_isr(2'b00, 8'h08, "R10 isr read");
    rd(2'b00, v); chk(v == 8'h00, "R10 second read returns 0", v, 0);

    // R5 priority
    pulse(16'h0020);
    expect_vec(8'h21); pulse(16'h0002);
    rd_isr(2'b00, 8'h0A, "R5 isr after higher line");

    // R10 specific and non-specific EOI
    wr(2'b00, 8'h61);
    rd_isr(2'b00, 8'h08, "R10 specific eoi");
    wr(2'b00, 8'h20);
    rd_isr(2'b00, 8'h00, "R10 nonspecific eoi");

    // R4 mask
    wr(2'b01, 8'h10);
    pulse(16'h0010);
    expect_vec(8'h25); pulse(16'h0020);
    wr(2'b00, 8'h20); wr(2'b01, 8'h00);

    // R6 bad cascade byte
    pulse(16'h0200);
    rd_isr(2'b00, 8'h00, "R6 no line2 mark on bad cascade");
    wr(2'b10, 8'h11); wr(2'b11, 8'h70); wr(2'b11, 8'h02); wr(2'b11, 8'h01);

    // R8 secondary accept
    expect_vec(8'h72); pulse(16'h0400);
    rd_isr(2'b00, 8'h04, "R8 primary line2 marked");
    rd_isr(2'b10, 8'h04, "R8 secondary local bit");
    wr(2'b10, 8'h20);
    rd_isr(2'b00, 8'h04, "R8 line2 held after secondary eoi");
    // R7 blocked while primary busy
    pulse(16'h0100);
    wr(2'b00, 8'h20);
    expect_vec(8'h70); pulse(16'h0100);
    wr(2'b10, 8'h20); wr(2'b00, 8'h20);

    // R9 simultaneous
    expect_vec(8'h20); pulse(16'h1001);
    rd_isr(2'b10, 8'h00, "R9 secondary not taken");
    wr(2'b00, 8'h20);

    // R11 automatic EOI on primary
    wr(2'b00, 8'h11); wr(2'b01, 8'h20); wr(2'b01, 8'h04); wr(2'b01, 8'h03);
    expect_vec(8'h26); pulse(16'h0040);
    rd_isr(2'b00, 8'h00, "R11 no isr bit in auto eoi");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "missing interrupt", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule